// File: doc/BRIEF.md
# Byte-Wide Boot Image Loader

This block copies a program image out of an external byte-wide read-only memory into on-chip memory as soon as reset is released. No command starts it. It walks the byte addresses upward from zero and holds each read for a fixed number of wait cycles. It gathers every four bytes into one 32-bit word, lowest byte first, and hands each word to the internal memory over a valid/ready write stream. Once the last word has been accepted it raises a sticky done flag. The image length, in bytes, is taken from a configuration input on the first clock edge after reset.

While the image loads, a dedicated select output enables the external memory. After loading has finished, the same 24-bit byte space can be reached through single-byte read and write requests from a DMA engine. Each such access uses the same wait timing and is marked by a separate chip enable.

Back-pressure rules: the word stream presents `mem_valid` together with a stable address and data until `mem_ready` is seen high at a clock edge. While a word is waiting, no new byte read starts. The DMA request port takes a request on a clock edge where both `dma_req_valid` and `dma_req_ready` are high. A read answer stays on `dma_rsp_valid`/`dma_rsp_data` until `dma_rsp_ready` is high at a clock edge. Write requests produce no answer.

Top module: `rom_boot_loader`

## Requirements
- R1: While `rst_n` is low, `boot_sel`, `rom_rd`, `rom_wr`, `rom_ce`, `mem_valid`, `boot_done`, `dma_req_ready` and `dma_rsp_valid` are all low. The first clock edge after release captures `cfg_len`. When that length is nonzero, the cycle after this edge shows `boot_sel`=1, `rom_rd`=1 and `rom_addr`=0.
- R2: Every byte read holds `rom_rd` high and `rom_addr` unchanged for exactly 16 consecutive cycles (parameter `WAIT_CYC`). The byte is taken from `rom_rdata` in the last of these cycles.
- R3: During loading, byte addresses are read once each, in ascending order from 0 up to length-1.
- R4: Packing is little-endian. The byte at address 4k+i lands in bits 8i+7:8i of word k, and word k is written at `mem_addr` = k.
- R5: When the length is not a multiple of four, the unused upper bytes of the final word are zero.
- R6: `mem_valid` stays high, with `mem_addr` and `mem_data` stable, until accepted. While `mem_valid` is high, `rom_rd` is low.
- R7: `boot_done` rises only after the last word has been accepted, and then stays high until reset. A length of zero gives `boot_done` with no read at all.
- R8: `boot_sel` is high only while the image is loading and is never high together with `rom_ce`.
- R9: `dma_req_ready` is low until `boot_done` is high. A request held pending during loading is taken only after loading has finished, and the requests are served one at a time.
- R10: A DMA read drives `rom_ce` and `rom_rd` at the requested address for 16 cycles. Then `dma_rsp_valid` presents the byte and holds it stable until `dma_rsp_ready`.
- R11: A DMA write drives `rom_ce` and `rom_wr` with `rom_wdata` at the requested address for 16 cycles and gives no response.
- R12: A change on `cfg_len` after the capture edge has no effect on the number of bytes loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 25 | Image length in bytes, captured after reset |
| rom_addr | output | 24 | Byte address to the external memory |
| boot_sel | output | 1 | External memory select while loading |
| rom_ce | output | 1 | External memory enable for DMA accesses |
| rom_rd | output | 1 | Read strobe |
| rom_wr | output | 1 | Write strobe |
| rom_wdata | output | 8 | Byte written by a DMA write |
| rom_rdata | input | 8 | Byte returned by the external memory |
| mem_valid | output | 1 | Packed word available |
| mem_ready | input | 1 | Internal memory accepts the word |
| mem_addr | output | 22 | Internal word address |
| mem_data | output | 32 | Packed word |
| boot_done | output | 1 | Image fully loaded (sticky) |
| dma_req_valid | input | 1 | DMA request present |
| dma_req_ready | output | 1 | DMA request can be taken |
| dma_req_write | input | 1 | 1 = write, 0 = read |
| dma_req_addr | input | 24 | DMA byte address |
| dma_req_wdata | input | 8 | DMA write byte |
| dma_rsp_valid | output | 1 | DMA read byte available |
| dma_rsp_ready | input | 1 | DMA read byte taken |
| dma_rsp_data | output | 8 | DMA read byte |

## Verification
The end of loading and the arrival of a DMA request can fall in the same cycle. To provoke this, the bench raises a DMA write before reset is released and keeps it pending through the whole load, while the word stream is throttled at random. The bench then checks four things: the request is not taken while `boot_done` is low, no write strobe reaches the external memory before that point, `dma_req_ready` rises in the same cycle as `boot_done`, and a later read returns the written byte. A second overlap, a word held by back-pressure while a byte read would otherwise begin, is checked by requiring `rom_rd` to be low for as long as `mem_valid` waits.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_BOOT_RD,
    ST_PUSH,
    ST_IDLE,
    ST_DMA,
    ST_RSP
  } ldr_state_t;

endpackage

// File: rtl/rom_strobe_timer.sv
module rom_strobe_timer #(
  parameter int WAIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = run && (cnt_q == CNT_W'(WAIT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R2
  fresh_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/byte_lane_packer.sv
module byte_lane_packer #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load,
  input  logic [7:0]         din,
  output logic [8*BYTES-1:0] word,
  output logic               full_next
);
  localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [LANE_W-1:0] lane_q;

  assign full_next = (lane_q == LANE_W'(BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
    end else if (clr) begin
      lane_q <= '0;
    end else if (load) begin
      lane_q <= full_next ? '0 : lane_q + LANE_W'(1);
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (clr) begin
        byte_q <= '0;
      end else if (load && (lane_q == LANE_W'(g))) begin
        byte_q <= din;
      end
    end
    assign word[8*g +: 8] = byte_q;
  end

  // R5
  no_clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && load));

endmodule

// File: rtl/rom_boot_loader.sv
module rom_boot_loader
  import boot_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int WAIT_CYC   = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [ADDR_W:0]                           cfg_len,
  output logic [ADDR_W-1:0]                         rom_addr,
  output logic                                      boot_sel,
  output logic                                      rom_ce,
  output logic                                      rom_rd,
  output logic                                      rom_wr,
  output logic [7:0]                                rom_wdata,
  input  logic [7:0]                                rom_rdata,
  output logic                                      mem_valid,
  input  logic                                      mem_ready,
  output logic [ADDR_W-$clog2(WORD_BYTES)-1:0]      mem_addr,
  output logic [8*WORD_BYTES-1:0]                   mem_data,
  output logic                                      boot_done,
  input  logic                                      dma_req_valid,
  output logic                                      dma_req_ready,
  input  logic                                      dma_req_write,
  input  logic [ADDR_W-1:0]                         dma_req_addr,
  input  logic [7:0]                                dma_req_wdata,
  output logic                                      dma_rsp_valid,
  input  logic                                      dma_rsp_ready,
  output logic [7:0]                                dma_rsp_data
);
  localparam int LEN_W  = ADDR_W + 1;
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int WA_W   = ADDR_W - $clog2(WORD_BYTES);

  ldr_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [WA_W-1:0]   waddr_q;
  logic              wr_q;
  logic [7:0]        wdata_q;
  logic [7:0]        rsp_q;
  logic              done_q;

  logic              tmr_run;
  logic              tmr_last;
  logic              pk_load;
  logic              pk_clr;
  logic              pk_full;
  logic [WORD_W-1:0] pk_word;

  assign tmr_run = (state_q == ST_BOOT_RD) || (state_q == ST_DMA);
  assign pk_load = (state_q == ST_BOOT_RD) && tmr_last;
  assign pk_clr  = mem_valid && mem_ready;

  rom_strobe_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (tmr_run),
    .last (tmr_last)
  );

  byte_lane_packer #(.BYTES(WORD_BYTES)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pk_clr),
    .load     (pk_load),
    .din      (rom_rdata),
    .word     (pk_word),
    .full_next(pk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      addr_q  <= '0;
      left_q  <= '0;
      waddr_q <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rsp_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_START: begin
          left_q <= cfg_len;
          if (cfg_len == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_BOOT_RD;
          end
        end
        ST_BOOT_RD: begin
          if (tmr_last) begin
            addr_q <= addr_q + ADDR_W'(1);
            left_q <= left_q - LEN_W'(1);
            if (pk_full || (left_q == LEN_W'(1))) begin
              state_q <= ST_PUSH;
            end
          end
        end
        ST_PUSH: begin
          if (mem_ready) begin
            waddr_q <= waddr_q + WA_W'(1);
            if (left_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_BOOT_RD;
            end
          end
        end
        ST_IDLE: begin
          if (dma_req_valid) begin
            addr_q  <= dma_req_addr;
            wr_q    <= dma_req_write;
            wdata_q <= dma_req_wdata;
            state_q <= ST_DMA;
          end
        end
        ST_DMA: begin
          if (tmr_last) begin
            if (wr_q) begin
              state_q <= ST_IDLE;
            end else begin
              rsp_q   <= rom_rdata;
              state_q <= ST_RSP;
            end
          end
        end
        ST_RSP: begin
          if (dma_rsp_ready) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rom_addr      = addr_q;
  assign boot_sel      = (state_q == ST_BOOT_RD) || (state_q == ST_PUSH);
  assign rom_ce        = (state_q == ST_DMA);
  assign rom_rd        = (state_q == ST_BOOT_RD) || ((state_q == ST_DMA) && !wr_q);
  assign rom_wr        = (state_q == ST_DMA) && wr_q;
  assign rom_wdata     = wdata_q;
  assign mem_valid     = (state_q == ST_PUSH);
  assign mem_addr      = waddr_q;
  assign mem_data      = pk_word;
  assign boot_done     = done_q;
  assign dma_req_ready = (state_q == ST_IDLE);
  assign dma_rsp_valid = (state_q == ST_RSP);
  assign dma_rsp_data  = rsp_q;

  // R2
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_run && !tmr_last) |=> (tmr_run && $stable(rom_addr)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_sel && rom_rd && tmr_last) |=> (rom_addr == $past(rom_addr) + ADDR_W'(1)));

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data) && $stable(mem_addr)));

  // R6
  stall_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !rom_rd);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);

  // R8
  select_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(boot_sel && rom_ce));

  // R9
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_ready |-> boot_done);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rsp_valid && !dma_rsp_ready) |=> (dma_rsp_valid && $stable(dma_rsp_data)));

endmodule

// File: tb/sim_rom_boot_loader.sv
module sim_rom_boot_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [24:0] cfg_len = '0;
  logic [23:0] rom_addr;
  logic        boot_sel, rom_ce, rom_rd, rom_wr;
  logic [7:0]  rom_wdata, rom_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [21:0] mem_addr;
  logic [31:0] mem_data;
  logic        boot_done;
  logic        dma_req_valid = 1'b0;
  logic        dma_req_ready;
  logic        dma_req_write = 1'b0;
  logic [23:0] dma_req_addr = '0;
  logic [7:0]  dma_req_wdata = '0;
  logic        dma_rsp_valid;
  logic        dma_rsp_ready = 1'b0;
  logic [7:0]  dma_rsp_data;

  rom_boot_loader u0 (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len),
    .rom_addr(rom_addr), .boot_sel(boot_sel), .rom_ce(rom_ce),
    .rom_rd(rom_rd), .rom_wr(rom_wr), .rom_wdata(rom_wdata), .rom_rdata(rom_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .boot_done(boot_done),
    .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
    .dma_req_write(dma_req_write), .dma_req_addr(dma_req_addr), .dma_req_wdata(dma_req_wdata),
    .dma_rsp_valid(dma_rsp_valid), .dma_rsp_ready(dma_rsp_ready), .dma_rsp_data(dma_rsp_data)
  );

  // external memory model: computed image plus a write overlay
  function automatic logic [7:0] img_byte(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  logic [255:0] wflag = '0;
  logic [7:0]   wbyte [0:255];
  assign rom_rdata = wflag[rom_addr[7:0]] ? wbyte[rom_addr[7:0]] : img_byte(int'(rom_addr[7:0]));
  always @(posedge clk) begin
    if (rom_ce && rom_wr) begin
      wflag[rom_addr[7:0]] <= 1'b1;
      wbyte[rom_addr[7:0]] <= rom_wdata;
    end
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // back-pressure source
  bit       rnd_ready = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= rnd_ready ? (lfsr[0] ^ lfsr[2]) : 1'b1;
  end

  // scoreboard
  typedef struct {
    logic [21:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic push_expected(int len);
    int nw;
    nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      exp_t e;
      e.a = 22'(k);
      e.d = '0;
      e.tag = "R4";
      for (int i = 0; i < 4; i++) begin
        if (4 * k + i < len) e.d[8*i +: 8] = img_byte(4 * k + i);
        else e.tag = "R5";
      end
      exp_q.push_back(e);
    end
  endtask

  logic        prev_stall = 1'b0;
  logic [31:0] prev_data;
  logic [21:0] prev_addr;
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected word", longint'(mem_addr), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.a, "R4", "word address", longint'(mem_addr), longint'(e.a));
        check(mem_data == e.d, e.tag, "word data", longint'(mem_data), longint'(e.d));
      end
    end
    if (rst_n && prev_stall) begin
      check(mem_valid && mem_data == prev_data && mem_addr == prev_addr, "R6",
            "held word", longint'(mem_data), longint'(prev_data));
    end
    prev_stall = rst_n && mem_valid && !mem_ready;
    prev_data  = mem_data;
    prev_addr  = mem_addr;
  end

  // strobe monitor for the loading phase
  int          run_len = 0;
  int          seen_bytes = 0;
  logic [23:0] run_addr = '0;
  logic [23:0] next_addr = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      run_len = 0;
      seen_bytes = 0;
      next_addr = '0;
    end else begin
      if (mem_valid && rom_rd) check(1'b0, "R6", "read during held word", 1, 0);
      if (boot_sel && rom_ce) check(1'b0, "R8", "select overlap", 1, 0);
      if (dma_req_ready && !boot_done) check(1'b0, "R9", "early dma ready", 1, 0);
      if (boot_sel && rom_rd) begin
        if (run_len == 0) begin
          check(rom_addr == next_addr, "R3", "byte order", longint'(rom_addr), longint'(next_addr));
          run_addr = rom_addr;
          run_len = 1;
        end else if (rom_addr == run_addr) begin
          run_len++;
        end else begin
          check(run_len == 16, "R2", "strobe length", run_len, 16);
          seen_bytes++;
          next_addr = run_addr + 24'd1;
          check(rom_addr == next_addr, "R3", "byte order", longint'(rom_addr), longint'(next_addr));
          run_addr = rom_addr;
          run_len = 1;
        end
      end else if (run_len != 0) begin
        check(run_len == 16, "R2", "strobe length", run_len, 16);
        seen_bytes++;
        next_addr = run_addr + 24'd1;
        run_len = 0;
      end
    end
  end

  task automatic boot_once(int len, bit rnd, bit poke_cfg, bit pend_dma);
    int t;
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    cfg_len = 25'(len);
    rnd_ready = rnd;
    exp_q.delete();
    push_expected(len);
    if (pend_dma) begin
      dma_req_valid = 1'b1;
      dma_req_write = 1'b1;
      dma_req_addr  = 24'h000105;
      dma_req_wdata = 8'ha5;
    end
    @(negedge clk);
    check(!boot_sel && !rom_rd && !rom_wr && !rom_ce && !mem_valid && !boot_done &&
          !dma_req_ready && !dma_rsp_valid, "R1", "reset outputs",
          {boot_sel, rom_rd, mem_valid, boot_done}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (len > 0) begin
      check(rom_rd && boot_sel && rom_addr == 0, "R1", "auto start",
            {rom_rd, boot_sel}, 3);
    end else begin
      check(boot_done && !rom_rd && !boot_sel, "R7", "zero length", boot_done, 1);
    end
    if (poke_cfg) begin
      @(posedge clk);
      #1;
      cfg_len = 25'(len * 4 + 3);
    end
    t = 0;
    while (!boot_done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(boot_done, "R7", "done reached", boot_done, 1);
    check(exp_q.size() == 0, "R7", "words left at done", exp_q.size(), 0);
    check(seen_bytes == len, poke_cfg ? "R12" : "R3", "bytes read", seen_bytes, len);
    check(!boot_sel, "R8", "select after done", boot_sel, 0);
    if (pend_dma) begin
      check(wflag == '0, "R9", "write before done", 1, 0);
      check(dma_req_ready, "R9", "ready at done", dma_req_ready, 1);
      @(posedge clk);
      #1;
      dma_req_valid = 1'b0;
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(boot_done, "R7", "done sticky", boot_done, 1);
    end
  endtask

  task automatic dma_op(bit wr, logic [23:0] a, logic [7:0] d, logic [7:0] exp_rd);
    int t;
    int n;
    bit bad;
    @(posedge clk);
    #1;
    dma_req_valid = 1'b1;
    dma_req_write = wr;
    dma_req_addr  = a;
    dma_req_wdata = d;
    t = 0;
    @(negedge clk);
    while (!dma_req_ready && t < 1000) begin
      @(negedge clk);
      t++;
    end
    @(posedge clk);
    #1;
    dma_req_valid = 1'b0;
    n = 0;
    bad = 1'b0;
    @(negedge clk);
    while (rom_ce && n < 100) begin
      if (rom_addr != a || boot_sel) bad = 1'b1;
      if (wr && !(rom_wr && !rom_rd && rom_wdata == d)) bad = 1'b1;
      if (!wr && !(rom_rd && !rom_wr)) bad = 1'b1;
      n++;
      @(negedge clk);
    end
    check(n == 16, wr ? "R11" : "R10", "access length", n, 16);
    check(!bad, wr ? "R11" : "R10", "access pins", bad, 0);
    if (wr) begin
      check(!dma_rsp_valid, "R11", "no write response", dma_rsp_valid, 0);
      check(dma_req_ready, "R9", "ready after write", dma_req_ready, 1);
    end else begin
      check(dma_rsp_valid && dma_rsp_data == exp_rd, "R10", "read data",
            longint'(dma_rsp_data), longint'(exp_rd));
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(dma_rsp_valid && dma_rsp_data == exp_rd, "R10", "held response",
              longint'(dma_rsp_data), longint'(exp_rd));
      end
      @(posedge clk);
      #1;
      dma_rsp_ready = 1'b1;
      @(posedge clk);
      #1;
      dma_rsp_ready = 1'b0;
      @(negedge clk);
      check(!dma_rsp_valid, "R10", "response released", dma_rsp_valid, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      errors++;
      $display("FAIL R7 watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    boot_once(16, 1'b0, 1'b0, 1'b0);   // R4 whole words, no back-pressure
    boot_once(10, 1'b1, 1'b0, 1'b0);   // R5 padded tail under back-pressure
    boot_once(1, 1'b1, 1'b0, 1'b0);    // R5 single byte
    boot_once(0, 1'b0, 1'b0, 1'b0);    // R7 empty image
    boot_once(10, 1'b0, 1'b1, 1'b0);   // R12 length changed mid-load
    boot_once(8, 1'b1, 1'b0, 1'b1);    // R9 request pending through the load
    t_wait_idle();
    dma_op(1'b0, 24'h000105, 8'h00, 8'ha5);          // R10 reads back the pending write
    dma_op(1'b1, 24'h0000ff, 8'h3c, 8'h00);          // R11
    dma_op(1'b0, 24'h0000ff, 8'h00, 8'h3c);          // R10
    dma_op(1'b0, 24'h000042, 8'h00, img_byte(8'h42)); // R10 untouched byte
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic t_wait_idle();
    int t;
    t = 0;
    @(negedge clk);
    while (!dma_req_ready && t < 1000) begin
      @(negedge clk);
      t++;
    end
    check(dma_req_ready, "R9", "idle after pending write", dma_req_ready, 1);
  endtask

endmodule